// File: doc/BRIEF.md
# Caption line serial decoder

This block pulls the two caption characters out of one selected video line. It takes one sliced luma bit per sample clock, a frame line count, a line-standard select and two enables. On an enabled line it hunts for the double-rate clock run-in, locks its bit phase to the last run-in edge, and confirms the start-bit pattern. It then samples sixteen data bits, least significant bit first, and emits them as two bytes on consecutive cycles. Each byte carries a low/high tag, a tag that says whether the line is a caption line or an extended-data line, and an odd-parity error flag.

Bit timing comes from a phase accumulator. One accumulator wrap is one data bit, and the increment is a runtime input, so the same logic serves both line standards at any sample rate. A line whose run-in, start bits or window end do not meet the rules produces no output at all. The bytes feed a downstream character store.

Top module: `cc_line_decoder`

## Requirements
- R1: With `std_625`=0, line 21 is decoded as caption data (`byte_xds`=0) and line 284 as extended data (`byte_xds`=1). Line 22 produces nothing in this mode.
- R2: With `std_625`=1, lines 22 and 335 are decoded as caption data (`byte_xds`=0). Lines 21 and 284 produce nothing in this mode.
- R3: `cap_en` gates the caption lines and `xds_en` gates the extended-data line, each independently of the other. A line whose enable is low produces no output.
- R4: Lock needs five consecutive run-in edge spacings within 0.375 to 0.625 of a data bit, as measured by the accumulator. Three good spacings, or spacings of 0.75 bit, give no output. Exactly five good spacings are enough.
- R5: After the last run-in edge, the three start-bit samples must read 0, 0, 1 in time order. Any other pattern gives no output for that line.
- R6: The sixteen data bits arrive least significant bit first. The first eight form the low byte, emitted with `byte_hi`=0. The next eight form the high byte, emitted with `byte_hi`=1 on the very next cycle.
- R7: `byte_perr` is 1 exactly when the emitted byte holds an even number of ones (odd parity failed).
- R8: If the line window closes before the sixteenth data bit is sampled, nothing is emitted for that line.
- R9: One accumulator wrap (2^16 over `phase_inc`) equals one data bit. Decoding works with 16 samples per bit (`phase_inc`=4096) and with 32 samples per bit (`phase_inc`=2048).
- R10: While and right after `rst` is high, `byte_vld`, `byte_data`, `byte_hi`, `byte_xds` and `byte_perr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| samp_bit | input | 1 | Sliced luma bit for this sample |
| line_num | input | 10 | Current line number within the frame |
| std_625 | input | 1 | 1 selects the 625-line standard, 0 the 525-line standard |
| cap_en | input | 1 | Enables decoding of caption lines |
| xds_en | input | 1 | Enables decoding of the extended-data line |
| phase_inc | input | 16 | Phase added per sample; 2^16 is one data bit |
| byte_vld | output | 1 | One-cycle strobe for an emitted byte |
| byte_data | output | 8 | Decoded byte including its parity bit |
| byte_hi | output | 1 | 0 for the low byte, 1 for the high byte |
| byte_xds | output | 1 | 1 when the byte came from the extended-data line |
| byte_perr | output | 1 | Odd-parity failure for this byte |

## Verification
The assertions assume that `line_num`, `std_625`, the enables and `phase_inc` stay constant for the whole of a line, and change only between lines. The window logic adds a pipeline stage, so a byte is tied to the line value two cycles before its strobe. The bench holds every setting steady from the first sample of a line until after a quiet gap on a non-target line. It also places every edge of the waveform on a whole sample, so the nominal spacing and the bit centres land exactly on accumulator wraps.

// File: rtl/cc_dec_pkg.sv
package cc_dec_pkg;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_HUNT,
    ST_SAMPLE,
    ST_EMIT_HI,
    ST_DONE
  } dec_state_t;

  localparam int START_BITS = 3;
  localparam int DATA_BITS  = 16;
  // time order of the start bits is index 0, 1, 2 -> 0, 0, 1
  localparam logic [START_BITS-1:0] START_PAT = 3'b100;

  function automatic logic parity_fail(input logic [7:0] b);
    return ~(^b);
  endfunction

endpackage

// File: rtl/cc_line_sel.sv
module cc_line_sel #(
  parameter int LINE_W   = 10,
  parameter int L525_CAP = 21,
  parameter int L525_XDS = 284,
  parameter int L625_CA  = 22,
  parameter int L625_CB  = 335
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LINE_W-1:0] line_num,
  input  logic              std_625,
  input  logic              cap_en,
  input  logic              xds_en,
  output logic              win,
  output logic              win_xds
);

  logic is_cap, is_xds;

  always_comb begin
    if (std_625)
      is_cap = (line_num == LINE_W'(L625_CA)) || (line_num == LINE_W'(L625_CB));
    else
      is_cap = (line_num == LINE_W'(L525_CAP));
    is_xds = !std_625 && (line_num == LINE_W'(L525_XDS));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      win     <= 1'b0;
      win_xds <= 1'b0;
    end else begin
      win     <= (is_cap && cap_en) || (is_xds && xds_en);
      win_xds <= is_xds;
    end
  end

endmodule

// File: rtl/cc_bit_timer.sv
module cc_bit_timer #(
  parameter int ACC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active,
  input  logic             resync,
  input  logic             samp_bit,
  input  logic [ACC_W-1:0] phase_inc,
  output logic             bit_o,
  output logic             edge_o,
  output logic             tick_o,
  output logic             spacing_ok_o
);

  localparam int HALF = 1 << (ACC_W - 1);
  localparam logic [ACC_W:0] SP_LO = (ACC_W+1)'(HALF - HALF / 4);
  localparam logic [ACC_W:0] SP_HI = (ACC_W+1)'(HALF + HALF / 4);

  logic [ACC_W-1:0] acc;
  logic [ACC_W:0]   acc_nxt;
  logic             bit_q, bit_p;

  assign acc_nxt      = {1'b0, acc} + {1'b0, phase_inc};
  assign bit_o        = bit_q;
  assign edge_o       = active && (bit_q != bit_p);
  assign tick_o       = active && acc_nxt[ACC_W];
  assign spacing_ok_o = (acc_nxt >= SP_LO) && (acc_nxt <= SP_HI);

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_q <= 1'b0;
      bit_p <= 1'b0;
      acc   <= '0;
    end else begin
      bit_q <= samp_bit;
      bit_p <= bit_q;
      if (!active || (edge_o && resync))
        acc <= '0;
      else
        acc <= acc_nxt[ACC_W-1:0];
    end
  end

endmodule

// File: rtl/cc_frame_fsm.sv
module cc_frame_fsm
  import cc_dec_pkg::*;
#(
  parameter int RUNIN_MIN = 5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       win,
  input  logic       win_xds,
  input  logic       bit_i,
  input  logic       edge_i,
  input  logic       tick_i,
  input  logic       spacing_ok_i,
  output logic       hunting,
  output logic       byte_vld,
  output logic [7:0] byte_data,
  output logic       byte_hi,
  output logic       byte_xds,
  output logic       byte_perr
);

  localparam int CNT_W    = $clog2(RUNIN_MIN + 1);
  localparam int LAST_IDX = START_BITS + DATA_BITS - 1;
  localparam int IDX_W    = $clog2(LAST_IDX + 1);

  dec_state_t           state;
  logic [CNT_W-1:0]     run_cnt;
  logic                 ref_ok;
  logic [IDX_W-1:0]     idx;
  logic [DATA_BITS-1:0] sr, sr_nxt;
  logic [7:0]           hi_hold;
  logic                 xds_q;

  assign hunting = (state == ST_HUNT);
  assign sr_nxt  = {bit_i, sr[DATA_BITS-1:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_OFF;
      run_cnt   <= '0;
      ref_ok    <= 1'b0;
      idx       <= '0;
      sr        <= '0;
      hi_hold   <= '0;
      xds_q     <= 1'b0;
      byte_vld  <= 1'b0;
      byte_data <= '0;
      byte_hi   <= 1'b0;
      byte_xds  <= 1'b0;
      byte_perr <= 1'b0;
    end else begin
      byte_vld <= 1'b0;
      case (state)
        ST_OFF: begin
          if (win) begin
            state   <= ST_HUNT;
            run_cnt <= '0;
            ref_ok  <= 1'b0;
            xds_q   <= win_xds;
          end
        end
        ST_HUNT: begin
          if (!win) begin
            state <= ST_OFF;
          end else if (edge_i) begin
            ref_ok <= 1'b1;
            if (ref_ok && spacing_ok_i) begin
              if (run_cnt != CNT_W'(RUNIN_MIN)) run_cnt <= run_cnt + 1'b1;
            end else begin
              run_cnt <= '0;
            end
          end else if (tick_i) begin
            if (run_cnt == CNT_W'(RUNIN_MIN) && bit_i == START_PAT[0]) begin
              state <= ST_SAMPLE;
              idx   <= IDX_W'(1);
            end else begin
              run_cnt <= '0;
              ref_ok  <= 1'b0;
            end
          end
        end
        ST_SAMPLE: begin
          if (!win) begin
            state <= ST_OFF;
          end else if (tick_i) begin
            idx <= idx + 1'b1;
            if (idx < IDX_W'(START_BITS)) begin
              if (bit_i != START_PAT[idx[1:0]]) state <= ST_DONE;
            end else begin
              sr <= sr_nxt;
              if (idx == IDX_W'(LAST_IDX)) begin
                byte_vld  <= 1'b1;
                byte_data <= sr_nxt[7:0];
                byte_hi   <= 1'b0;
                byte_xds  <= xds_q;
                byte_perr <= parity_fail(sr_nxt[7:0]);
                hi_hold   <= sr_nxt[15:8];
                state     <= ST_EMIT_HI;
              end
            end
          end
        end
        ST_EMIT_HI: begin
          byte_vld  <= 1'b1;
          byte_data <= hi_hold;
          byte_hi   <= 1'b1;
          byte_perr <= parity_fail(hi_hold);
          state     <= ST_DONE;
        end
        ST_DONE: begin
          if (!win) state <= ST_OFF;
        end
        default: state <= ST_OFF;
      endcase
    end
  end

endmodule

// File: rtl/cc_line_decoder.sv
module cc_line_decoder #(
  parameter int LINE_W    = 10,
  parameter int ACC_W     = 16,
  parameter int RUNIN_MIN = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              samp_bit,
  input  logic [LINE_W-1:0] line_num,
  input  logic              std_625,
  input  logic              cap_en,
  input  logic              xds_en,
  input  logic [ACC_W-1:0]  phase_inc,
  output logic              byte_vld,
  output logic [7:0]        byte_data,
  output logic              byte_hi,
  output logic              byte_xds,
  output logic              byte_perr
);

  logic win, win_xds, hunting;
  logic bit_s, edge_s, tick_s, spacing_ok;

  cc_line_sel #(.LINE_W(LINE_W)) u_sel (
    .clk(clk), .rst(rst), .line_num(line_num), .std_625(std_625),
    .cap_en(cap_en), .xds_en(xds_en), .win(win), .win_xds(win_xds)
  );

  cc_bit_timer #(.ACC_W(ACC_W)) u_timer (
    .clk(clk), .rst(rst), .active(win), .resync(hunting),
    .samp_bit(samp_bit), .phase_inc(phase_inc), .bit_o(bit_s),
    .edge_o(edge_s), .tick_o(tick_s), .spacing_ok_o(spacing_ok)
  );

  cc_frame_fsm #(.RUNIN_MIN(RUNIN_MIN)) u_fsm (
    .clk(clk), .rst(rst), .win(win), .win_xds(win_xds), .bit_i(bit_s),
    .edge_i(edge_s), .tick_i(tick_s), .spacing_ok_i(spacing_ok),
    .hunting(hunting), .byte_vld(byte_vld), .byte_data(byte_data),
    .byte_hi(byte_hi), .byte_xds(byte_xds), .byte_perr(byte_perr)
  );

endmodule

// File: rtl/cc_line_decoder_chk.sv
module cc_line_decoder_chk #(
  parameter int LINE_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic [LINE_W-1:0] line_num,
  input logic              std_625,
  input logic              cap_en,
  input logic              xds_en,
  input logic              byte_vld,
  input logic [7:0]        byte_data,
  input logic              byte_hi,
  input logic              byte_xds,
  input logic              byte_perr
);

  logic tgt, xds_line;
  assign xds_line = !std_625 && (line_num == LINE_W'(284));
  assign tgt = std_625 ? (cap_en && (line_num == LINE_W'(22) || line_num == LINE_W'(335)))
                       : ((cap_en && line_num == LINE_W'(21)) || (xds_en && xds_line));

  AST_HI_FOLLOWS_LO: assert property (@(posedge clk) disable iff (rst)
    byte_vld && !byte_hi |=> byte_vld && byte_hi); // R6
  AST_HI_HAS_LO: assert property (@(posedge clk) disable iff (rst)
    byte_vld && byte_hi |-> $past(byte_vld && !byte_hi)); // R6
  AST_ONLY_TARGET_LINE: assert property (@(posedge clk) disable iff (rst)
    byte_vld && !byte_hi |-> $past(tgt, 2)); // R3
  AST_XDS_TAG: assert property (@(posedge clk) disable iff (rst)
    byte_vld && !byte_hi |-> byte_xds == $past(xds_line, 2)); // R1
  AST_PARITY_FLAG: assert property (@(posedge clk) disable iff (rst)
    byte_vld |-> byte_perr == ~(^byte_data)); // R7
  AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !byte_vld && byte_data == 8'd0); // R10

endmodule

bind cc_line_decoder cc_line_decoder_chk #(.LINE_W(LINE_W)) u_chk (
  .clk(clk), .rst(rst), .line_num(line_num), .std_625(std_625),
  .cap_en(cap_en), .xds_en(xds_en), .byte_vld(byte_vld),
  .byte_data(byte_data), .byte_hi(byte_hi), .byte_xds(byte_xds),
  .byte_perr(byte_perr)
);

// File: tb/cc_line_decoder_test.sv
module cc_line_decoder_test;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       samp_bit = 1'b0;
  logic [9:0] line_num = '0;
  logic       std_625 = 1'b0;
  logic       cap_en = 1'b1;
  logic       xds_en = 1'b1;
  logic [15:0] phase_inc = 16'd4096;
  logic       byte_vld, byte_hi, byte_xds, byte_perr;
  logic [7:0] byte_data;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  int cap_n = 0;
  logic [7:0] cap_d [4];
  logic       cap_h [4];
  logic       cap_x [4];
  logic       cap_p [4];
  int         cap_c [4];

  cc_line_decoder uut (
    .clk(clk), .rst(rst), .samp_bit(samp_bit), .line_num(line_num),
    .std_625(std_625), .cap_en(cap_en), .xds_en(xds_en), .phase_inc(phase_inc),
    .byte_vld(byte_vld), .byte_data(byte_data), .byte_hi(byte_hi),
    .byte_xds(byte_xds), .byte_perr(byte_perr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst && byte_vld) begin
      if (cap_n < 4) begin
        cap_d[cap_n] = byte_data;
        cap_h[cap_n] = byte_hi;
        cap_x[cap_n] = byte_xds;
        cap_p[cap_n] = byte_perr;
        cap_c[cap_n] = cyc;
      end
      cap_n = cap_n + 1;
    end
  end

  // fields: [31] std_625, [30] output expected, [29] xds tag, [25:16] line, [15:8] high, [7:0] low
  localparam logic [31:0] VEC [7] = '{
    {1'b0, 1'b1, 1'b0, 3'b0, 10'd21,  8'h80, 8'hC1},  // R1
    {1'b0, 1'b1, 1'b1, 3'b0, 10'd284, 8'h07, 8'h15},  // R1
    {1'b0, 1'b0, 1'b0, 3'b0, 10'd22,  8'h80, 8'hC1},  // R1
    {1'b1, 1'b1, 1'b0, 3'b0, 10'd22,  8'hFE, 8'h52},  // R2
    {1'b1, 1'b1, 1'b0, 3'b0, 10'd335, 8'h2A, 8'h01},  // R2
    {1'b1, 1'b0, 1'b0, 3'b0, 10'd21,  8'h2A, 8'h01},  // R2
    {1'b1, 1'b0, 1'b0, 3'b0, 10'd284, 8'h2A, 8'h01}   // R2
  };

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input int n);
    repeat (n) begin
      @(negedge clk);
      samp_bit = v;
    end
  endtask

  task automatic send_line(input logic std, input int ln, input logic [7:0] lo,
                           input logic [7:0] hi, input int rin_n, input int rin_len,
                           input logic [2:0] st, input int nbits);
    int sp;
    logic [15:0] word;
    sp = std ? 32 : 16;
    word = {hi, lo};
    @(negedge clk);
    std_625 = std;
    phase_inc = std ? 16'd2048 : 16'd4096;
    line_num = 10'(ln);
    cap_n = 0;
    drive(1'b0, 40);
    for (int h = 0; h < rin_n; h++) drive((h % 2) == 0, rin_len);
    for (int s = 0; s < 3; s++) drive(st[s], sp);
    for (int b = 0; b < nbits; b++) drive(word[b], sp);
    if (nbits == 16) drive(1'b0, 40);
    @(negedge clk);
    line_num = 10'd0;
    drive(1'b0, 30);
  endtask

  task automatic expect_pair(input string req, input logic [7:0] lo, input logic [7:0] hi,
                             input logic xds);
    chk(cap_n == 2, req, cap_n, 2);
    if (cap_n == 2) begin
      chk(cap_d[0] == lo && !cap_h[0], req, {cap_h[0], cap_d[0]}, {1'b0, lo});
      chk(cap_d[1] == hi && cap_h[1], req, {cap_h[1], cap_d[1]}, {1'b1, hi});
      chk(cap_x[0] == xds && cap_x[1] == xds, req, {cap_x[0], cap_x[1]}, {xds, xds});
      chk(cap_p[0] == ~(^lo) && cap_p[1] == ~(^hi), "R7", {cap_p[0], cap_p[1]},
          {~(^lo), ~(^hi)});
      chk(cap_c[1] == cap_c[0] + 1, "R6", cap_c[1] - cap_c[0], 1);
    end
  endtask

  task automatic expect_none(input string req);
    chk(cap_n == 0, req, cap_n, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(byte_vld == 0 && byte_data == 0 && byte_hi == 0 && byte_xds == 0 && byte_perr == 0,
        "R10", {byte_vld, byte_hi, byte_xds, byte_perr, byte_data}, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(byte_vld == 0 && byte_data == 0, "R10", {byte_vld, byte_data}, 0);

    // table walk: R1, R2, R6, R7, R9 (625 entries run at 32 samples per bit)
    for (int i = 0; i < 7; i++) begin
      send_line(VEC[i][31], int'(VEC[i][25:16]), VEC[i][7:0], VEC[i][15:8], 14,
                VEC[i][31] ? 16 : 8, 3'b100, 16);
      if (VEC[i][30]) expect_pair(VEC[i][31] ? "R2/R9" : "R1", VEC[i][7:0], VEC[i][15:8],
                                  VEC[i][29]);
      else expect_none(VEC[i][31] ? "R2" : "R1");
    end

    // R7: parity failures on both bytes
    send_line(1'b0, 21, 8'h41, 8'h00, 14, 8, 3'b100, 16);
    expect_pair("R7", 8'h41, 8'h00, 1'b0);
    chk(cap_p[0] == 1'b1 && cap_p[1] == 1'b1, "R7", {cap_p[0], cap_p[1]}, 2'b11);

    // R4: too few run-in edges, off-rate run-in, and the minimum that locks
    send_line(1'b0, 21, 8'hC1, 8'h80, 4, 8, 3'b100, 16);
    expect_none("R4");
    send_line(1'b0, 21, 8'hC1, 8'h80, 14, 12, 3'b100, 16);
    expect_none("R4");
    send_line(1'b0, 21, 8'h15, 8'h07, 6, 8, 3'b100, 16);
    expect_pair("R4", 8'h15, 8'h07, 1'b0);

    // R5: wrong start patterns
    send_line(1'b0, 21, 8'hC1, 8'h80, 14, 8, 3'b110, 16);
    expect_none("R5");
    send_line(1'b0, 21, 8'hC1, 8'h80, 14, 8, 3'b000, 16);
    expect_none("R5");

    // R8: window closes after 12 data bits
    send_line(1'b0, 21, 8'hC1, 8'h80, 14, 8, 3'b100, 12);
    expect_none("R8");

    // R3: independent enables
    cap_en = 1'b0;
    send_line(1'b0, 21, 8'hC1, 8'h80, 14, 8, 3'b100, 16);
    expect_none("R3");
    send_line(1'b0, 284, 8'h15, 8'h07, 14, 8, 3'b100, 16);
    expect_pair("R3", 8'h15, 8'h07, 1'b1);
    cap_en = 1'b1;
    xds_en = 1'b0;
    send_line(1'b0, 284, 8'h15, 8'h07, 14, 8, 3'b100, 16);
    expect_none("R3");
    send_line(1'b1, 335, 8'h52, 8'hFE, 14, 16, 3'b100, 16);
    expect_pair("R3", 8'h52, 8'hFE, 1'b0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule